// File: doc/BRIEF.md
# Twelve-Hour Clock Hours Counter

This block keeps the hour of a 12-hour clock. It steps through 1, 2, …, 9, 10, 11, 12 and then goes back to 1. Its value is never 0, 13, 14 or 15. The units of the hour leave the block as a 4-bit BCD digit. The tens of the hour leave it as a single bit, because that digit can only be 0 or 1. One indicator, such as a decimal point, can therefore show it.

The counter is made of two 4-bit counter stages and a small control section. The control watches the present hour. At the two rollover points it tells the stages to load preset values: at 9 it goes to 10, and at 12 it goes back to 1. At every other hour it tells the units stage to count up. A count enable lets a slower time base step the hour. A wrap pulse tells the next stage of a clock, such as an AM/PM flag, that the hour is leaving 12. Display decoding is done outside the block.

Top module: `hour_counter12`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the hour is 12: the units digit is 2 and the tens bit is 1. The first enabled rising edge after reset gives 1.
- R2: On a rising clock edge with enable high, hours 1 to 8, 10 and 11 advance by one. The units digit goes up by 1 and the tens bit stays the same. Nothing changes between rising edges.
- R3: On an enabled rising edge at hour 9 (units 9, tens bit 0), the units digit is loaded with 0 and the tens bit is set, which gives 10.
- R4: On an enabled rising edge at hour 12 (units 2, tens bit 1), the units digit is loaded with 1 and the tens bit is cleared, which gives 1.
- R5: When enable is low, a rising edge leaves both the units digit and the tens bit unchanged.
- R6: The wrap output is high exactly while the hour is 12 and enable is high. It is a combinational function of the present state and of enable.
- R7: The units digit never exceeds 9. The hour value (10 × tens + units) always lies between 1 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the hour changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low; sets the hour to 12 |
| countEn | input | 1 | Count enable; when high, the next rising edge advances the hour |
| unitsBcd | output | 4 | Units digit of the hour in BCD |
| tensOn | output | 1 | Tens digit of the hour (0 or 1) |
| wrapPulse | output | 1 | High while the hour is 12 and enable is high |

## Verification
The bench first runs 36 back-to-back enabled clocks from reset. These cover three full cycles, so each rollover (9 to 10 and 12 to 1) is crossed several times, and each step is compared with a reference hour computed arithmetically. Every sampled value is also checked to be a legal hour, which separates a correct design from one that leaks 0 or 13 to 15. Next comes an alternating enable pattern. A held hour must not move, and wrap must follow enable at 12; this separates a design that gates on enable from one that does not. Last, the bench asserts reset in the middle of a count. This shows that the preset to 12 does not wait for a clock edge.

// File: rtl/hour_counter12_pkg.sv
package hour_counter12_pkg;
  localparam int DIGIT_W  = 4;
  localparam int BCD_MAX  = 9;
  localparam int HOUR_MAX = 12;
  localparam int HOUR_MIN = 1;
  localparam logic [DIGIT_W-1:0] TOP_UNITS = DIGIT_W'(HOUR_MAX % 10);
  localparam logic [DIGIT_W-1:0] TOP_TENS  = DIGIT_W'(HOUR_MAX / 10);
  localparam logic [DIGIT_W-1:0] MIN_UNITS = DIGIT_W'(HOUR_MIN);

  typedef struct packed {
    logic               unitsInc;
    logic               unitsLoad;
    logic [DIGIT_W-1:0] unitsLoadVal;
    logic               tensLoad;
    logic [DIGIT_W-1:0] tensLoadVal;
  } stageStrobes_t;
endpackage

// File: rtl/hour_count_stage.sv
module hour_count_stage #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incEn,
  input  logic         loadEn,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       q <= RST_VAL;
    else if (loadEn) q <= loadVal;
    else if (incEn)  q <= q + W'(1);
  end
endmodule

// File: rtl/hour_count_ctrl.sv
module hour_count_ctrl
  import hour_counter12_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               countEn,
  input  logic [DIGIT_W-1:0] unitsVal,
  input  logic [DIGIT_W-1:0] tensVal,
  output stageStrobes_t      strobes,
  output logic               wrapPulse
);
  logic atNine, atTwelve, rollPoint;

  assign atNine    = (tensVal == '0) && (unitsVal == DIGIT_W'(BCD_MAX));
  assign atTwelve  = (tensVal == TOP_TENS) && (unitsVal == TOP_UNITS);
  assign rollPoint = atNine || atTwelve;

  always_comb begin
    strobes.unitsInc     = countEn && !rollPoint;
    strobes.unitsLoad    = countEn && rollPoint;
    strobes.unitsLoadVal = atTwelve ? MIN_UNITS : '0;
    strobes.tensLoad     = countEn && rollPoint;
    strobes.tensLoadVal  = atNine ? DIGIT_W'(1) : '0;
  end

  assign wrapPulse = countEn && atTwelve;

  // R6: wrap never fires without enable
  assert_wrap_needs_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> countEn);
  // R2: the units stage never gets both an increment and a load
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.unitsInc, strobes.unitsLoad}));
endmodule

// File: rtl/hour_count_datapath.sv
module hour_count_datapath
  import hour_counter12_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               countEn,
  input  stageStrobes_t      strobes,
  output logic [DIGIT_W-1:0] unitsQ,
  output logic [DIGIT_W-1:0] tensQ
);
  hour_count_stage #(.W(DIGIT_W), .RST_VAL(TOP_UNITS)) uUnits (
    .clk(clk), .rstN(rstN),
    .incEn(strobes.unitsInc), .loadEn(strobes.unitsLoad),
    .loadVal(strobes.unitsLoadVal), .q(unitsQ));

  hour_count_stage #(.W(DIGIT_W), .RST_VAL(TOP_TENS)) uTens (
    .clk(clk), .rstN(rstN),
    .incEn(1'b0), .loadEn(strobes.tensLoad),
    .loadVal(strobes.tensLoadVal), .q(tensQ));

  logic [DIGIT_W+3:0] hourVal;
  assign hourVal = (DIGIT_W+4)'(tensQ) * (DIGIT_W+4)'(10) + (DIGIT_W+4)'(unitsQ);

  // R7: the hour value stays legal
  assert_legal_hour_R7: assert property (@(posedge clk) disable iff (!rstN)
    (unitsQ <= DIGIT_W'(BCD_MAX)) && (hourVal >= HOUR_MIN) && (hourVal <= HOUR_MAX));
  // R5: a disabled edge leaves the state alone
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(unitsQ) && $stable(tensQ));
  // R3: 9 rolls to 10
  assert_nine_to_ten_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && hourVal == 9) |=> (unitsQ == '0) && (tensQ == DIGIT_W'(1)));
  // R4: 12 rolls to 1
  assert_twelve_to_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && hourVal == HOUR_MAX) |=> (unitsQ == MIN_UNITS) && (tensQ == '0));
  // R2: ordinary steps add one to the units
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && hourVal != 9 && hourVal != HOUR_MAX) |=>
      (unitsQ == $past(unitsQ) + DIGIT_W'(1)) && $stable(tensQ));
endmodule

// File: rtl/hour_counter12.sv
module hour_counter12
  import hour_counter12_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               countEn,
  output logic [DIGIT_W-1:0] unitsBcd,
  output logic               tensOn,
  output logic               wrapPulse
);
  stageStrobes_t      strobes;
  logic [DIGIT_W-1:0] unitsQ, tensQ;

  hour_count_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .countEn(countEn),
    .unitsVal(unitsQ), .tensVal(tensQ),
    .strobes(strobes), .wrapPulse(wrapPulse));

  hour_count_datapath uData (
    .clk(clk), .rstN(rstN), .countEn(countEn),
    .strobes(strobes), .unitsQ(unitsQ), .tensQ(tensQ));

  assign unitsBcd = unitsQ;
  assign tensOn   = tensQ[0];

  // R1: the tens stage only ever holds 0 or 1
  assert_tens_single_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    tensQ[DIGIT_W-1:1] == '0);
endmodule

// File: tb/sim_hour_counter12.sv
`timescale 1ns/1ps
module sim_hour_counter12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0;
  logic [3:0] unitsBcd;
  logic tensOn, wrapPulse;
  int nChecks = 0;
  int nFails = 0;
  int expHour;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hour_counter12 u0 (.clk(clk), .rstN(rstN), .countEn(countEn),
    .unitsBcd(unitsBcd), .tensOn(tensOn), .wrapPulse(wrapPulse));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hourNow();
    return (tensOn ? 10 : 0) + int'(unitsBcd);
  endfunction

  // sampled just before a rising edge; checks value, legality and wrap
  task automatic checkState(input string tag);
    int h = hourNow();
    check(h == expHour, tag, h, expHour);
    check(unitsBcd <= 9 && h >= 1 && h <= 12, "R7 legal hour", h, expHour);
    check(wrapPulse == (countEn && expHour == 12), "R6 wrap", int'(wrapPulse),
          int'(countEn && expHour == 12));
  endtask

  function automatic string stepTag(input int h);
    if (h == 9)  return "R3 nine to ten";
    if (h == 12) return "R4 twelve to one";
    return "R2 step";
  endfunction

  initial begin
    #45;
    expHour = 12;
    check(hourNow() == 12, "R1 reset value", hourNow(), 12);
    check(wrapPulse == 1'b0, "R6 wrap low without enable", int'(wrapPulse), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(hourNow() == 12, "R1 held after reset", hourNow(), 12);

    // 36 enabled clocks: three full cycles
    countEn = 1'b1;
    for (int i = 0; i < 36; i++) begin
      string t;
      #1; checkState("R6 pre-edge state");
      t = stepTag(expHour);
      @(negedge clk);
      expHour = expHour % 12 + 1;
      check(hourNow() == expHour, t, hourNow(), expHour);
    end

    // alternating enable: hold on disabled edges (R5)
    for (int i = 0; i < 30; i++) begin
      countEn = i[0];
      #1; checkState("R5 pre-edge state");
      @(negedge clk);
      if (countEn) expHour = expHour % 12 + 1;
      check(hourNow() == expHour, countEn ? "R2 enabled step" : "R5 hold", hourNow(), expHour);
    end

    // mid-count async reset, applied between edges
    countEn = 1'b0;
    #5; rstN = 1'b0; #1;
    expHour = 12;
    check(hourNow() == 12, "R1 async reset", hourNow(), 12);
    @(negedge clk); rstN = 1'b1; countEn = 1'b1;
    #1; checkState("R6 wrap at 12 after reset");
    @(negedge clk);
    expHour = 1;
    check(hourNow() == 1, "R1 first edge gives 1", hourNow(), 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule